// File: doc/BRIEF.md
# Three-Channel Control and Status Register Bank

This block is the register front end of a three-channel data formatter. A simple synchronous bus drives a 2-bit command, an 8-bit byte address and 32-bit write data, and gets 32-bit read data back. Each channel has one writable control word. The control word holds a one-bit enable, a two-bit priority level and a three-bit packet-length code. These fields go straight to the formatter datapath as continuous outputs. Each channel also has one read-only status word. It reports the eight-bit free-space count that the channel FIFO supplies.

A write takes effect on the clock edge where the command is WRITE. It uses the address and data present in that cycle. A read is served by a small response machine with two states, RD_IDLE and RD_RESP. On a READ command the addressed word is captured and the machine moves to RD_RESP, so the word appears on the read bus in the next cycle. Any other command moves the machine to RD_IDLE, where the read bus is driven to zero. A READ command issued while in RD_RESP keeps the machine in RD_RESP and captures the new word. Reset is asynchronous and active low, and it forces RD_IDLE.

Top module: `chan_regbank`

## Requirements
- R1: While rst_n is low, every channel shows enable 0, priority 3 and length code 0 on its outputs, and the read bus is zero.
- R2: A WRITE (command 1) to byte address 0x00, 0x04 or 0x08 loads channel 0, 1 or 2 from the write data. Bit 0 goes to the enable, bits 2:1 to the priority and bits 5:3 to the length code. The outputs show the new values after that clock edge.
- R3: A READ (command 2) of a control address returns, in the next cycle, length in bits 5:3, priority in bits 2:1 and enable in bit 0, with bits 31:6 zero.
- R4: A READ of byte address 0x10, 0x14 or 0x18 returns, in the next cycle, the free-space input of channel 0, 1 or 2 as it was at the command's clock edge, in bits 7:0, with bits 31:8 zero.
- R5: A WRITE to a status address or to an unmapped address leaves all control outputs unchanged. Write-data bits 31:6 have no effect.
- R6: A READ of an unmapped address returns zero in the next cycle.
- R7: Command 0 (idle) and command 3 change no control output, whatever the address and data.
- R8: The read bus is zero in every cycle that does not directly follow a READ command.
- R9: Address matching uses all eight address bits, so a misaligned address such as 0x01 or 0x02 is unmapped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_cmd | input | 2 | 0 idle, 1 write, 2 read, 3 treated as idle |
| bus_addr | input | 8 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid the cycle after a READ |
| ch_enable | output | 3 | Enable of each channel, bit c for channel c |
| ch_prio | output | 6 | Priority of each channel, bits 2c+1:2c |
| ch_len | output | 9 | Length code of each channel, bits 3c+2:3c |
| fifo_space | input | 24 | Free FIFO space of each channel, bits 8c+7:8c |

## Verification
The read response of one command and the write of the next command fall in the same cycle. This happens when a READ of a control word is followed at once by a WRITE to that same word. The bench issues exactly that pair. In the cycle after the read, it expects the read bus to carry the old contents while the control outputs still hold the old values. One cycle later it expects the outputs to show the new values and the read bus to be back at zero. Status reads are also run back to back while the free-space input changes between commands. This shows that each response carries the value present at its own command edge.

// File: rtl/crb_pkg.sv
package crb_pkg;
    localparam int PRIO_W = 2;
    localparam int LEN_W  = 3;
    localparam logic [PRIO_W-1:0] PRIO_RST = 2'd3;

    typedef enum logic [1:0] {
        CMD_IDLE  = 2'd0,
        CMD_WRITE = 2'd1,
        CMD_READ  = 2'd2,
        CMD_RSVD  = 2'd3
    } bus_cmd_e;

    typedef enum logic {
        RD_IDLE = 1'b0,
        RD_RESP = 1'b1
    } rd_state_e;

    // Packed order gives enable at bit 0, priority at 2:1, length at 5:3.
    typedef struct packed {
        logic [LEN_W-1:0]  len;
        logic [PRIO_W-1:0] prio;
        logic              en;
    } ctrl_fields_t;
endpackage

// File: rtl/crb_decode.sv
module crb_decode #(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int STAT_BASE = 'h10,
    parameter int STRIDE    = 4
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [NUM_CH-1:0] ctrl_hit,
    output logic [NUM_CH-1:0] stat_hit
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_match
        localparam logic [ADDR_W-1:0] CTRL_ADDR = ADDR_W'(CTRL_BASE + c * STRIDE);
        localparam logic [ADDR_W-1:0] STAT_ADDR = ADDR_W'(STAT_BASE + c * STRIDE);
        assign ctrl_hit[c] = (addr == CTRL_ADDR);
        assign stat_hit[c] = (addr == STAT_ADDR);
    end
endmodule

// File: rtl/crb_ctrl_reg.sv
module crb_ctrl_reg
    import crb_pkg::*;
(
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  ctrl_fields_t wr_data,
    output ctrl_fields_t fields
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fields.len  <= '0;
            fields.prio <= PRIO_RST;
            fields.en   <= 1'b0;
        end else if (wr_en) begin
            fields <= wr_data;
        end
    end

    // R2: a selected write lands on the next edge
    p_write_lands_r2: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (fields == $past(wr_data)));

    // R5, R7: without a selected write the word holds
    p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> $stable(fields));

    // R1: reset values visible when reset is released
    p_reset_val_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (fields.en == 1'b0 && fields.prio == PRIO_RST && fields.len == '0));
endmodule

// File: rtl/crb_rd_path.sv
module crb_rd_path
    import crb_pkg::*;
#(
    parameter int NUM_CH  = 3,
    parameter int DATA_W  = 32,
    parameter int SPACE_W = 8
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      rd_req,
    input  logic [NUM_CH-1:0]         ctrl_hit,
    input  logic [NUM_CH-1:0]         stat_hit,
    input  ctrl_fields_t [NUM_CH-1:0] ctrl_all,
    input  logic [NUM_CH*SPACE_W-1:0] space,
    output logic [DATA_W-1:0]         rdata
);
    rd_state_e         state, state_nxt;
    logic [DATA_W-1:0] rd_word;
    logic [DATA_W-1:0] rd_q;

    always_comb begin
        rd_word = '0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (ctrl_hit[c]) rd_word = rd_word | DATA_W'(ctrl_all[c]);
            if (stat_hit[c]) rd_word = rd_word | DATA_W'(space[c*SPACE_W +: SPACE_W]);
        end
    end

    always_comb begin
        unique case (state)
            RD_IDLE: state_nxt = rd_req ? RD_RESP : RD_IDLE;
            RD_RESP: state_nxt = rd_req ? RD_RESP : RD_IDLE;
            default: state_nxt = RD_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= RD_IDLE;
        else        state <= state_nxt;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)      rd_q <= '0;
        else if (rd_req) rd_q <= rd_word;
    end

    always_comb begin
        unique case (state)
            RD_IDLE: rdata = '0;
            RD_RESP: rdata = rd_q;
            default: rdata = '0;
        endcase
    end

    // R6: unmapped read answers zero
    p_unmapped_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_req && !(|{ctrl_hit, stat_hit})) |=> (rdata == '0));

    for (genvar c = 0; c < NUM_CH; c++) begin : g_chk
        // R4: status answer is the space value at the command edge
        p_status_sample_r4: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && stat_hit[c]) |=> (rdata == DATA_W'($past(space[c*SPACE_W +: SPACE_W]))));
        // R3: control answer carries the fields present at the command edge
        p_ctrl_read_r3: assert property (@(posedge clk) disable iff (!rst_n)
            (rd_req && ctrl_hit[c]) |=> (rdata == DATA_W'($past(ctrl_all[c]))));
    end
endmodule

// File: rtl/chan_regbank.sv
module chan_regbank
    import crb_pkg::*;
#(
    parameter int NUM_CH    = 3,
    parameter int ADDR_W    = 8,
    parameter int DATA_W    = 32,
    parameter int SPACE_W   = 8,
    parameter int CTRL_BASE = 'h00,
    parameter int STAT_BASE = 'h10,
    parameter int STRIDE    = 4
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic [1:0]                bus_cmd,
    input  logic [ADDR_W-1:0]         bus_addr,
    input  logic [DATA_W-1:0]         bus_wdata,
    output logic [DATA_W-1:0]         bus_rdata,
    output logic [NUM_CH-1:0]         ch_enable,
    output logic [NUM_CH*PRIO_W-1:0]  ch_prio,
    output logic [NUM_CH*LEN_W-1:0]   ch_len,
    input  logic [NUM_CH*SPACE_W-1:0] fifo_space
);
    localparam int CF_W = $bits(ctrl_fields_t);

    logic [NUM_CH-1:0]         ctrl_hit, stat_hit, wr_sel;
    logic                      is_wr, is_rd;
    ctrl_fields_t              wr_fields;
    ctrl_fields_t [NUM_CH-1:0] ctrl_all;
    logic                      unused_wdata_hi;

    assign is_wr           = (bus_cmd == CMD_WRITE);
    assign is_rd           = (bus_cmd == CMD_READ);
    assign wr_sel          = ctrl_hit & {NUM_CH{is_wr}};
    assign wr_fields       = ctrl_fields_t'(bus_wdata[CF_W-1:0]);
    assign unused_wdata_hi = ^bus_wdata[DATA_W-1:CF_W];

    crb_decode #(
        .NUM_CH(NUM_CH), .ADDR_W(ADDR_W), .CTRL_BASE(CTRL_BASE),
        .STAT_BASE(STAT_BASE), .STRIDE(STRIDE)
    ) u_decode (
        .addr(bus_addr), .ctrl_hit(ctrl_hit), .stat_hit(stat_hit)
    );

    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        crb_ctrl_reg u_reg (
            .clk(clk), .rst_n(rst_n), .wr_en(wr_sel[c]),
            .wr_data(wr_fields), .fields(ctrl_all[c])
        );
        assign ch_enable[c]                 = ctrl_all[c].en;
        assign ch_prio[c*PRIO_W +: PRIO_W]  = ctrl_all[c].prio;
        assign ch_len[c*LEN_W +: LEN_W]     = ctrl_all[c].len;
    end

    crb_rd_path #(
        .NUM_CH(NUM_CH), .DATA_W(DATA_W), .SPACE_W(SPACE_W)
    ) u_rd (
        .clk(clk), .rst_n(rst_n), .rd_req(is_rd),
        .ctrl_hit(ctrl_hit), .stat_hit(stat_hit), .ctrl_all(ctrl_all),
        .space(fifo_space), .rdata(bus_rdata)
    );

    // R9: at most one word matches any address
    p_one_match_r9: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({ctrl_hit, stat_hit}));

    // R7: idle and code 3 leave every output quiet
    p_idle_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd == CMD_IDLE || bus_cmd == CMD_RSVD) |=>
            ($stable(ch_enable) && $stable(ch_prio) && $stable(ch_len)));

    // R8: read bus zero unless the previous command was a READ
    p_rdata_gap_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_cmd != CMD_READ) |=> (bus_rdata == '0));

    // R5: no write to a control word leaves the outputs steady
    p_no_stray_write_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !(is_wr && (|ctrl_hit)) |=>
            ($stable(ch_enable) && $stable(ch_prio) && $stable(ch_len)));
endmodule

// File: tb/sim_chan_regbank.sv
module sim_chan_regbank;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  cmd = 2'd0;
    logic [7:0]  addr = 8'd0;
    logic [31:0] wdata = 32'd0;
    logic [23:0] space = 24'd0;
    logic [31:0] rdata;
    logic [2:0]  en;
    logic [5:0]  prio;
    logic [8:0]  len;

    logic [2:0] m_en = 3'd0;
    logic [5:0] m_prio = 6'h3f;
    logic [8:0] m_len = 9'd0;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [31:0] rd;
        logic [2:0]  en;
        logic [5:0]  prio;
        logic [8:0]  len;
        string       tag;
    } exp_t;

    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chan_regbank u0 (
        .clk(clk), .rst_n(rst_n), .bus_cmd(cmd), .bus_addr(addr),
        .bus_wdata(wdata), .bus_rdata(rdata), .ch_enable(en),
        .ch_prio(prio), .ch_len(len), .fifo_space(space)
    );

    function automatic logic [31:0] model_rd(input logic [7:0] a, input logic [23:0] sp);
        int ch;
        case (a)
            8'h00, 8'h04, 8'h08: begin
                ch = int'(a) / 4;
                return {26'd0, m_len[ch*3 +: 3], m_prio[ch*2 +: 2], m_en[ch]};
            end
            8'h10, 8'h14, 8'h18: begin
                ch = (int'(a) - 16) / 4;
                return {24'd0, sp[ch*8 +: 8]};
            end
            default: return 32'd0;
        endcase
    endfunction

    // Driver: one bus cycle, expected result pushed to the scoreboard
    task automatic bus(input logic [1:0] c, input logic [7:0] a, input logic [31:0] d,
                       input logic [23:0] sp, input string tag);
        exp_t e;
        int   ch;
        @(negedge clk);
        cmd = c; addr = a; wdata = d; space = sp;
        e.rd = (c == 2'd2) ? model_rd(a, sp) : 32'd0;
        if (c == 2'd1 && (a == 8'h00 || a == 8'h04 || a == 8'h08)) begin
            ch = int'(a) / 4;
            m_en[ch]          = d[0];
            m_prio[ch*2 +: 2] = d[2:1];
            m_len[ch*3 +: 3]  = d[5:3];
        end
        e.en = m_en; e.prio = m_prio; e.len = m_len; e.tag = tag;
        q.push_back(e);
    endtask

    // Monitor: compare one item per cycle, after the edge has settled
    initial begin
        forever begin
            @(posedge clk);
            #2;
            if (q.size() > 0) begin
                exp_t e;
                e = q.pop_front();
                checks++;
                if (rdata !== e.rd || en !== e.en || prio !== e.prio || len !== e.len) begin
                    fails++;
                    $display("FAIL %s: rdata=%h en=%b prio=%b len=%b expected rdata=%h en=%b prio=%b len=%b",
                             e.tag, rdata, en, prio, len, e.rd, e.en, e.prio, e.len);
                end
            end
        end
    end

    task automatic do_reset(input string tag);
        wait (q.size() == 0);
        @(negedge clk);
        rst_n = 1'b0; cmd = 2'd0; addr = 8'd0; wdata = 32'd0;
        m_en = 3'd0; m_prio = 6'h3f; m_len = 9'd0;
        @(posedge clk);
        #2;
        checks++;
        if (rdata !== 32'd0 || en !== 3'd0 || prio !== 6'h3f || len !== 9'd0) begin
            fails++;
            $display("FAIL %s: rdata=%h en=%b prio=%b len=%b expected rdata=0 en=000 prio=111111 len=0",
                     tag, rdata, en, prio, len);
        end
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    initial begin
        #(CLK_PERIOD * 50000);
        fails++;
        $display("FAIL watchdog: run did not complete, expected completion");
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        do_reset("R1 reset state");
        bus(2'd2, 8'h00, 32'd0, 24'h000000, "R3 R1 read default ctrl0");
        bus(2'd2, 8'h08, 32'd0, 24'h000000, "R3 R1 read default ctrl2");
        bus(2'd1, 8'h04, 32'h0000_002B, 24'h000000, "R2 write ctrl1");
        bus(2'd2, 8'h04, 32'd0, 24'h000000, "R3 read ctrl1");
        bus(2'd1, 8'h08, 32'hFFFF_FFFF, 24'h000000, "R2 R5 write ctrl2 all ones");
        bus(2'd2, 8'h08, 32'd0, 24'h000000, "R3 R5 reserved reads zero");
        bus(2'd1, 8'h14, 32'hFFFF_FFFF, 24'h000000, "R5 write status ignored");
        bus(2'd2, 8'h14, 32'd0, 24'h005A00, "R4 read status ch1");
        bus(2'd1, 8'h0C, 32'h0000_003F, 24'h005A00, "R5 write unmapped 0x0C");
        bus(2'd1, 8'h01, 32'h0000_003F, 24'h005A00, "R9 write misaligned 0x01");
        bus(2'd1, 8'h40, 32'h0000_003F, 24'h005A00, "R5 write unmapped 0x40");
        bus(2'd2, 8'h0C, 32'd0, 24'h005A00, "R6 read unmapped 0x0C");
        bus(2'd2, 8'h02, 32'd0, 24'h005A00, "R9 R6 read misaligned 0x02");
        bus(2'd3, 8'h00, 32'h0000_003F, 24'h005A00, "R7 code 3 ignored");
        bus(2'd0, 8'h04, 32'h0000_0000, 24'h005A00, "R7 idle ignored");
        bus(2'd1, 8'h00, 32'h0000_0009, 24'h005A00, "R2 write ctrl0");
        bus(2'd2, 8'h00, 32'd0, 24'h005A00, "R3 read after write");
        bus(2'd1, 8'h00, 32'h0000_0000, 24'h005A00, "R3 R8 response while write lands");
        bus(2'd0, 8'h00, 32'd0, 24'h005A00, "R8 idle after write");
        bus(2'd2, 8'h10, 32'd0, 24'h00_00_77, "R4 read status ch0");
        bus(2'd2, 8'h18, 32'd0, 24'hC3_00_11, "R4 read status ch2");
        bus(2'd2, 8'h18, 32'd0, 24'h01_00_11, "R4 status tracks new space");
        bus(2'd0, 8'h18, 32'd0, 24'h01_00_11, "R8 rdata clears after read");
        bus(2'd1, 8'h08, 32'h0000_0015, 24'h01_00_11, "R2 write ctrl2");
        do_reset("R1 reset reloads values");
        bus(2'd2, 8'h04, 32'd0, 24'h000000, "R1 R3 ctrl1 after reset");
        bus(2'd0, 8'h00, 32'd0, 24'h000000, "R8 final idle");
        wait (q.size() == 0);
        #(CLK_PERIOD);
        $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule